// File: doc/BRIEF.md
# Host Window Decoder with Satellite Control Byte

This block sits on a host expansion bus with byte-wide data. Inside the expansion region it decodes four 2 KB windows, one for each of four satellite processors. A qualified access to a window drives that window's active-low select, which enables the host side of the processor's dual-port memory. The memory arrays and the processors are outside this block.

The block also holds one control byte at the last offset of the region, and the host can write it and read it back. The byte carries two bits for each satellite processor. One bit holds that processor's active-low reset line asserted. The other bit chooses where the dual-port window appears in the processor's local map: at $0000 when set, or at $7800 when clear. At a system reset the byte loads 0xFF, so every processor starts held in reset with its window at $0000. Software then loads a processor's window and clears its reset bit to start it. For example, writing 0xFD starts processor 0 alone.

Every output is registered. A select, a read-back value or a new control setting appears in the first cycle after the clock edge that samples the host access.

Top module: `hostwin_top`

## Requirements
- R1: A window access is an active rdStb or wrStb, with baseHit high, at an offset between 0x0000 and 0x1FFF. After such an access, winSelN[k] goes low for exactly one cycle, where k = offset[12:11]: 0x0000–0x07FF gives 0, 0x0800–0x0FFF gives 1, 0x1000–0x17FF gives 2 and 0x1800–0x1FFF gives 3. The other selects stay high.
- R2: When baseHit is low, when neither strobe is active, or when the offset is 0x2000 or higher, every winSelN bit is high in the following cycle.
- R3: A write with baseHit high at offset 0x3FFF loads wrData into the control byte at that clock edge.
- R4: A read with baseHit high at offset 0x3FFF places the control byte on rdData in the next cycle. In every other case rdData is 0x00.
- R5: Bit 2n+1 of the control byte drives cpuResetN[n]. A value of 1 holds cpuResetN[n] low, and a value of 0 drives it high.
- R6: Bit 2n of the control byte drives mapLow[n]. A value of 1 sets mapLow[n] high, placing the window at local $0000. A value of 0 sets it low, placing the window at $7800.
- R7: While rstN is low, the control byte is 0xFF, all cpuResetN bits are low, all mapLow bits are high, all winSelN bits are high and rdData is 0x00.
- R8: Writes at offsets 0x2000–0x3FFE, and writes with baseHit low, leave the control byte unchanged. Reads at offsets 0x2000–0x3FFE return 0x00.
- R9: When a read and a write of the control byte fall in the same cycle, rdData returns the value held before the write, and the new value takes effect on the outputs in that same following cycle.
- R10: Writing 0xFF and then 0xFD leaves cpuResetN = 4'b0001 and mapLow = 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | System reset, active low |
| hostAddr | input | 14 | Offset within the expansion region |
| wrData | input | 8 | Host write data |
| rdStb | input | 1 | Host read strobe, active high |
| wrStb | input | 1 | Host write strobe, active high |
| baseHit | input | 1 | High when the upper host address matches the region base |
| winSelN | output | 4 | Active-low dual-port window selects, one per processor |
| cpuResetN | output | 4 | Active-low reset line of each satellite processor |
| mapLow | output | 4 | Window placement of each processor: 1 = $0000, 0 = $7800 |
| rdData | output | 8 | Read-back data for the control byte; 0x00 otherwise |

## Verification
Two functions can fall in the same cycle: read-back of the control byte and an update of that byte, when both strobes are active at offset 0x3FFF. The bench drives both strobes together with a fresh data value. It checks that rdData shows the old byte while cpuResetN and mapLow already reflect the new one. Random steps also mix reads and writes on the register and on window addresses, with baseHit toggled. A reference model in the bench judges every one of these cycles.

// File: rtl/hostwin_pkg.sv
package hostwin_pkg;
  localparam int CPU_COUNT = 4;

  typedef struct packed {
    logic                 regWr;
    logic                 regRd;
    logic [CPU_COUNT-1:0] winHit;
  } strobe_t;
endpackage

// File: rtl/hostwin_decode.sv
module hostwin_decode
  import hostwin_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int WIN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              baseHit,
  output strobe_t           strb
);
  localparam int IDX_W = $clog2(CPU_COUNT);
  localparam int LOW_W = WIN_W + IDX_W;

  logic             access;
  logic             inWinArea;
  logic             regHit;
  logic [IDX_W-1:0] winIdx;

  assign access    = baseHit & (rdStb | wrStb);
  assign inWinArea = (hostAddr[ADDR_W-1:LOW_W] == '0);
  assign winIdx    = hostAddr[LOW_W-1:WIN_W];
  assign regHit    = (hostAddr == {ADDR_W{1'b1}});

  assign strb.regWr = baseHit & wrStb & regHit;
  assign strb.regRd = baseHit & rdStb & regHit;

  for (genvar i = 0; i < CPU_COUNT; i++) begin : gWinHit
    assign strb.winHit[i] = access & inWinArea & (winIdx == IDX_W'(i));
  end

  // R8
  reg_not_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr || strb.regRd) |-> (strb.winHit == '0));

  // R2
  no_base_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !baseHit |-> (strb.winHit == '0 && !strb.regWr && !strb.regRd));
endmodule

// File: rtl/hostwin_regs.sv
module hostwin_regs
  import hostwin_pkg::*;
#(
  parameter logic [2*CPU_COUNT-1:0] RESET_VAL = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [2*CPU_COUNT-1:0] wrData,
  output logic [CPU_COUNT-1:0]   winSelN,
  output logic [CPU_COUNT-1:0]   cpuResetN,
  output logic [CPU_COUNT-1:0]   mapLow,
  output logic [2*CPU_COUNT-1:0] rdData
);
  localparam int DATA_W = 2 * CPU_COUNT;

  logic [DATA_W-1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= RESET_VAL;
      winSelN <= '1;
      rdData  <= '0;
    end else begin
      if (strb.regWr) ctrlReg <= wrData;
      winSelN <= ~strb.winHit;
      rdData  <= strb.regRd ? ctrlReg : '0;
    end
  end

  for (genvar n = 0; n < CPU_COUNT; n++) begin : gPair
    assign cpuResetN[n] = ~ctrlReg[2*n+1];
    assign mapLow[n]    = ctrlReg[2*n];
  end

  // R3
  reg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.regWr |=> (ctrlReg == $past(wrData)));

  // R8
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.regWr |=> $stable(ctrlReg));

  // R9
  read_old_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.regRd |=> (rdData == $past(ctrlReg)));

  // R2
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.winHit == '0) |=> (winSelN == '1));

  // R4
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.regRd |=> (rdData == '0));
endmodule

// File: rtl/hostwin_top.sv
module hostwin_top
  import hostwin_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int WIN_W  = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      hostAddr,
  input  logic [2*CPU_COUNT-1:0] wrData,
  input  logic                   rdStb,
  input  logic                   wrStb,
  input  logic                   baseHit,
  output logic [CPU_COUNT-1:0]   winSelN,
  output logic [CPU_COUNT-1:0]   cpuResetN,
  output logic [CPU_COUNT-1:0]   mapLow,
  output logic [2*CPU_COUNT-1:0] rdData
);
  strobe_t strb;

  hostwin_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) uDecode (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .rdStb(rdStb),
    .wrStb(wrStb), .baseHit(baseHit), .strb(strb)
  );

  hostwin_regs uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .winSelN(winSelN), .cpuResetN(cpuResetN), .mapLow(mapLow),
    .rdData(rdData)
  );

  // R1
  one_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~winSelN));

  // R1
  window_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.winHit != '0) |=> ($countones(~winSelN) == 1));
endmodule

// File: tb/hostwin_top_test.sv
`timescale 1ns/1ps
module hostwin_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] hostAddr = '0;
  logic [7:0]  wrData = '0;
  logic        rdStb = 1'b0, wrStb = 1'b0, baseHit = 1'b0;
  logic [3:0]  winSelN, cpuResetN, mapLow;
  logic [7:0]  rdData;

  int total = 0;
  int bad = 0;
  logic [7:0] model = 8'hFF;

  always #4 clk = ~clk;

  hostwin_top uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .wrData(wrData),
    .rdStb(rdStb), .wrStb(wrStb), .baseHit(baseHit), .winSelN(winSelN),
    .cpuResetN(cpuResetN), .mapLow(mapLow), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expSel(input logic [13:0] a, input logic r, input logic w, input logic h);
    if (h && (r || w) && a < 14'h2000) return ~(4'b0001 << a[12:11]);
    return 4'hF;
  endfunction

  function automatic logic [3:0] expRst(input logic [7:0] m);
    logic [3:0] v;
    for (int n = 0; n < 4; n++) v[n] = ~m[2*n+1];
    return v;
  endfunction

  function automatic logic [3:0] expMap(input logic [7:0] m);
    logic [3:0] v;
    for (int n = 0; n < 4; n++) v[n] = m[2*n];
    return v;
  endfunction

  task automatic step(input string tag, input logic [13:0] a, input logic r,
                      input logic w, input logic h, input logic [7:0] d);
    logic [3:0] eSel;
    logic [7:0] eRd;
    @(negedge clk);
    hostAddr = a; rdStb = r; wrStb = w; baseHit = h; wrData = d;
    eSel = expSel(a, r, w, h);
    eRd  = (h && r && a == 14'h3FFF) ? model : 8'h00;
    if (h && w && a == 14'h3FFF) model = d;
    @(posedge clk);
    #1;
    check({tag, " winSelN"}, {4'h0, winSelN}, {4'h0, eSel});
    check({tag, " rdData"}, rdData, eRd);
    check({tag, " cpuResetN"}, {4'h0, cpuResetN}, {4'h0, expRst(model)});
    check({tag, " mapLow"}, {4'h0, mapLow}, {4'h0, expMap(model)});
    @(negedge clk);
    rdStb = 1'b0; wrStb = 1'b0; baseHit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    check("R7 ctrl reset", {4'h0, cpuResetN}, 8'h00);
    check("R7 map reset", {4'h0, mapLow}, 8'h0F);
    check("R7 sel reset", {4'h0, winSelN}, 8'h0F);
    check("R7 rd reset", rdData, 8'h00);
    @(negedge clk); rstN = 1'b1;

    step("R4 read reset value", 14'h3FFF, 1, 0, 1, 8'h00);
    step("R1 win0 low edge", 14'h0000, 1, 0, 1, 8'h00);
    step("R1 win0 top edge", 14'h07FF, 0, 1, 1, 8'h00);
    step("R1 win1 bottom", 14'h0800, 1, 0, 1, 8'h00);
    step("R1 win2", 14'h1234, 0, 1, 1, 8'h00);
    step("R1 win3 top", 14'h1FFF, 1, 0, 1, 8'h00);
    step("R2 gap start", 14'h2000, 1, 0, 1, 8'h00);
    step("R2 no strobe", 14'h0100, 0, 0, 1, 8'h00);
    step("R2 no base", 14'h0900, 1, 1, 0, 8'h00);
    // R10 boot sequence
    step("R10 write FF", 14'h3FFF, 0, 1, 1, 8'hFF);
    step("R10 write FD", 14'h3FFF, 0, 1, 1, 8'hFD);
    step("R10 read FD", 14'h3FFF, 1, 0, 1, 8'h00);
    // R5 R6 individual pairs
    step("R5 R6 pattern 9C", 14'h3FFF, 0, 1, 1, 8'h9C);
    step("R5 R6 pattern 63", 14'h3FFF, 0, 1, 1, 8'h63);
    // R8 ignored writes
    step("R8 gap write", 14'h3FFE, 0, 1, 1, 8'h00);
    step("R8 no base write", 14'h3FFF, 0, 1, 0, 8'hAA);
    step("R8 gap read", 14'h2ABC, 1, 0, 1, 8'h00);
    step("R8 readback kept", 14'h3FFF, 1, 0, 1, 8'h00);
    // R9 simultaneous read and write
    step("R9 rd+wr", 14'h3FFF, 1, 1, 1, 8'h5A);
    step("R9 rd after", 14'h3FFF, 1, 0, 1, 8'h00);
    step("R3 write A5", 14'h3FFF, 0, 1, 1, 8'hA5);

    for (int i = 0; i < 400; i++) begin
      logic [13:0] a;
      int kind;
      kind = $urandom_range(0, 3);
      case (kind)
        0: a = 14'h3FFF;
        1: a = 14'($urandom_range(0, 16'h1FFF));
        2: a = 14'($urandom_range(16'h2000, 16'h3FFE));
        default: a = 14'($urandom);
      endcase
      step("R1/R3/R4/R9 random", a, 1'($urandom), 1'($urandom),
           ($urandom_range(0, 4) != 0), 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule